// File: doc/BRIEF.md
# Interrupt Priority and Target Register Bank

This block is the memory-mapped storage for per-interrupt configuration in an interrupt distributor. Each of `NUM_IRQ` interrupts owns one priority byte and one target-processor byte. Four interrupts share each 32-bit word. Software reaches the bank through a simple request/response port that carries one access per request. An access is either a full aligned word or a single byte. A read returns its data one cycle after the request.

Only the upper `PRIO_BITS` bits of a priority byte are stored, and only the low `NUM_CPU` bits of a target byte are stored. All other bits read as zero, so software can find out what is implemented by writing all ones and reading the value back. Addresses that lie inside the priority or target window but past the last implemented interrupt read as zero and drop writes.

A read-only type word reports the interrupt count and the processor count. A read-only identification word returns a fixed value set by a parameter. Arbitration by priority and interrupt delivery are done by other blocks, which use the stored fields.

Top module: `irqcfg_bank`

Address map (byte addresses, `ADDR_W` = 12):
- 0x004: type word.
- 0x008: identification word.
- 0x400 + n: priority byte of interrupt n.
- 0x800 + n: target byte of interrupt n.
- Any other address reads zero.

## Requirements
- R1: After reset, every priority and target byte reads as zero.
- R2: A word written into the priority window (0x400 + 4k) reads back with the low 8-`PRIO_BITS` bits of every byte lane forced to zero. The lanes are byte 0 in bits [7:0] through byte 3 in bits [31:24], and the upper `PRIO_BITS` bits of each lane are kept.
- R3: Writing 0xFFFFFFFF to a priority word makes it read back as the implemented mask in all four lanes. With the default 5 bits this is 0xF8F8F8F8.
- R4: A byte access (`req_byte`=1) to address A touches only lane A[1:0]. A byte write takes its data from `req_wdata[7:0]` and leaves the other three lanes of the word unchanged. A byte read returns the lane in `rsp_rdata[7:0]` with bits [31:8] at zero.
- R5: In the target window (0x800 + 4k), bits at positions `NUM_CPU` and above in each byte read as zero whatever was written.
- R6: In the priority or target window, an offset at or above `NUM_IRQ` reads as zero. A write there changes no stored field.
- R7: The type word at 0x004 reads as {24'b0, `NUM_CPU`-1 in [7:5], `NUM_IRQ`/32-1 in [4:0]}. With the defaults this is 0x00000061.
- R8: Writes to the type word and to the identification word (0x008, value `ID_VALUE`) leave what they read unchanged.
- R9: Every read request gives exactly one `rsp_valid` pulse on the next cycle. A write request gives no response.
- R10: Control-window addresses other than 0x004 and 0x008, and the whole window at 0xC00 and above, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = single-byte access, 0 = aligned word access |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data; a byte write uses bits [7:0] |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |

## Verification
The bench writes all ones and a mixed pattern to priority and target words. A design with a wrong mask would show low priority bits, or target bits for processors that do not exist. It writes single bytes into words that already hold data, so lane decoding that disturbs neighbouring bytes or shifts the byte to the wrong lane shows up at once.

Word writes go both to the last implemented word and to the first offset past `NUM_IRQ`. An off-by-one range check would either read back data past the limit or drop the last legal word. Writes aimed at the type and identification words check that a decode letting them through would change the value read.

// File: rtl/irqcfg_pkg.sv
package irqcfg_pkg;

  typedef enum logic [1:0] {
    WIN_CTRL = 2'd0,
    WIN_PRIO = 2'd1,
    WIN_TGT  = 2'd2,
    WIN_NONE = 2'd3
  } win_e;

  localparam int unsigned LANES = 4;

  // one-hot lane enable for a byte access, all lanes for a word access
  function automatic logic [LANES-1:0] lane_enables(input logic is_byte,
                                                    input logic [1:0] lane);
    logic [LANES-1:0] en;
    if (is_byte) begin
      en = '0;
      en[lane] = 1'b1;
    end else begin
      en = '1;
    end
    return en;
  endfunction

endpackage

// File: rtl/irqcfg_decode.sv
module irqcfg_decode
  import irqcfg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned NUM_IRQ = 64,
  localparam int unsigned WIN_W  = ADDR_W - 2,
  localparam int unsigned WORD_W = WIN_W - 2
) (
  input  logic              req_byte,
  input  logic [ADDR_W-1:0] req_addr,
  output win_e              win,
  output logic [WORD_W-1:0] word_idx,
  output logic [1:0]        lane,
  output logic [LANES-1:0]  lane_en,
  output logic              in_range
);

  logic [WIN_W-1:0] offset;

  always_comb begin
    win      = win_e'(req_addr[ADDR_W-1 -: 2]);
    offset   = req_addr[WIN_W-1:0];
    word_idx = offset[WIN_W-1:2];
    lane     = offset[1:0];
    lane_en  = lane_enables(req_byte, offset[1:0]);
    in_range = (32'(offset) < NUM_IRQ);
  end

endmodule

// File: rtl/irqcfg_field_array.sv
module irqcfg_field_array #(
  parameter int unsigned NUM_ENTRY = 64,
  parameter int unsigned FIELD_W   = 5,
  parameter bit          MSB_ALIGN = 1'b1,
  parameter int unsigned WORD_W    = 8,
  localparam int unsigned SHIFT    = MSB_ALIGN ? (8 - FIELD_W) : 0,
  localparam int unsigned STORE_W  = NUM_ENTRY * FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [3:0]        wr_lanes,
  input  logic [31:0]       wr_data,
  input  logic [WORD_W-1:0] rd_word,
  output logic [31:0]       rd_data
);

  logic [STORE_W-1:0] store_q;
  logic [STORE_W-1:0] store_d;

  // next state, one entry per generated slice
  for (genvar e = 0; e < NUM_ENTRY; e++) begin : g_entry
    localparam int unsigned WRD = e / 4;
    localparam int unsigned LN  = e % 4;
    logic hit;
    logic [7:0] wbyte;
    assign hit   = wr_en && (32'(wr_word) == WRD) && wr_lanes[LN];
    assign wbyte = wr_data[8*LN +: 8];
    assign store_d[e*FIELD_W +: FIELD_W] =
      hit ? FIELD_W'(wbyte >> SHIFT) : store_q[e*FIELD_W +: FIELD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (wr_en) begin
      store_q <= store_d;
    end
  end

  // read: expand each stored field back into its byte lane
  always_comb begin
    rd_data = '0;
    for (int e = 0; e < NUM_ENTRY; e++) begin
      if (32'(rd_word) == (e / 4)) begin
        rd_data[8*(e%4) +: 8] = 8'(store_q[e*FIELD_W +: FIELD_W]) << SHIFT;
      end
    end
  end

endmodule

// File: rtl/irqcfg_bank.sv
module irqcfg_bank
  import irqcfg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_IRQ   = 64,
  parameter int unsigned NUM_CPU   = 4,
  parameter int unsigned PRIO_BITS = 5,
  parameter logic [31:0] ID_VALUE  = 32'h0000_143B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_byte,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata
);

  localparam int unsigned WIN_W  = ADDR_W - 2;
  localparam int unsigned WORD_W = WIN_W - 2;
  localparam logic [4:0]  IRQ_FLD = 5'(NUM_IRQ / 32 - 1);
  localparam logic [2:0]  CPU_FLD = 3'(NUM_CPU - 1);
  localparam logic [31:0] TYPE_VALUE = {24'b0, CPU_FLD, IRQ_FLD};
  localparam logic [WORD_W-1:0] TYPE_WORD = WORD_W'(1);
  localparam logic [WORD_W-1:0] ID_WORD   = WORD_W'(2);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // decode
  win_e              win;
  logic [WORD_W-1:0] word_idx;
  logic [1:0]        lane;
  logic [LANES-1:0]  lane_en;
  logic              in_range;

  irqcfg_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_IRQ (NUM_IRQ)
  ) i_decode (
    .req_byte (req_byte),
    .req_addr (req_addr),
    .win      (win),
    .word_idx (word_idx),
    .lane     (lane),
    .lane_en  (lane_en),
    .in_range (in_range)
  );

  // write steering
  logic [31:0] wr_lanes_data;
  logic        wr_ok;
  logic        prio_wr;
  logic        tgt_wr;

  always_comb begin
    wr_lanes_data = req_byte ? {4{req_wdata[7:0]}} : req_wdata;
    wr_ok         = req_valid && req_write && in_range;
    prio_wr       = wr_ok && (win == WIN_PRIO);
    tgt_wr        = wr_ok && (win == WIN_TGT);
  end

  logic [31:0] prio_rd;
  logic [31:0] tgt_rd;

  irqcfg_field_array #(
    .NUM_ENTRY (NUM_IRQ),
    .FIELD_W   (PRIO_BITS),
    .MSB_ALIGN (1'b1),
    .WORD_W    (WORD_W)
  ) i_prio (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (prio_wr),
    .wr_word  (word_idx),
    .wr_lanes (lane_en),
    .wr_data  (wr_lanes_data),
    .rd_word  (word_idx),
    .rd_data  (prio_rd)
  );

  irqcfg_field_array #(
    .NUM_ENTRY (NUM_IRQ),
    .FIELD_W   (NUM_CPU),
    .MSB_ALIGN (1'b0),
    .WORD_W    (WORD_W)
  ) i_tgt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (tgt_wr),
    .wr_word  (word_idx),
    .wr_lanes (lane_en),
    .wr_data  (wr_lanes_data),
    .rd_word  (word_idx),
    .rd_data  (tgt_rd)
  );

  // read mux
  logic [31:0] word_val;
  logic [31:0] rd_val;
  logic        rd_req;

  always_comb begin
    word_val = '0;
    unique case (win)
      WIN_CTRL: begin
        if (word_idx == TYPE_WORD)    word_val = TYPE_VALUE;
        else if (word_idx == ID_WORD) word_val = ID_VALUE;
      end
      WIN_PRIO: if (in_range) word_val = prio_rd;
      WIN_TGT:  if (in_range) word_val = tgt_rd;
      default:  word_val = '0;
    endcase
    rd_val = req_byte ? {24'b0, word_val[8*lane +: 8]} : word_val;
    rd_req = req_valid && !req_write;
  end

  // response registers
  logic        rsp_valid_d;
  logic [31:0] rsp_rdata_d;
  logic        rsp_valid_q;
  logic [31:0] rsp_rdata_q;

  always_comb begin
    rsp_valid_d = rd_req;
    rsp_rdata_d = rd_req ? rd_val : rsp_rdata_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      if (rd_req) rsp_rdata_q <= rsp_rdata_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

endmodule

// File: rtl/irqcfg_bank_chk.sv
module irqcfg_bank_chk #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_IRQ   = 64,
  parameter int unsigned NUM_CPU   = 4,
  parameter int unsigned PRIO_BITS = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_byte,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata
);

  localparam int unsigned WIN_W = ADDR_W - 2;
  localparam logic [7:0]  PM8 = 8'(8'hFF << (8 - PRIO_BITS));
  localparam logic [7:0]  CM8 = 8'((16'd1 << NUM_CPU) - 1);
  localparam logic [31:0] PM32 = {4{PM8}};
  localparam logic [31:0] CM32 = {4{CM8}};
  localparam logic [31:0] TYPE_EXP =
    {24'b0, 3'(NUM_CPU - 1), 5'(NUM_IRQ / 32 - 1)};

  logic rd;
  logic [1:0] win;
  logic beyond;

  assign rd     = req_valid && !req_write;
  assign win    = req_addr[ADDR_W-1 -: 2];
  assign beyond = (32'(req_addr[WIN_W-1:0]) >= NUM_IRQ);

  // R9
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);

  // R9
  wr_noresp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !rsp_valid);

  // R2
  prio_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !req_byte && win == 2'd1) |=> ((rsp_rdata & ~PM32) == 32'd0));

  // R5
  tgt_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !req_byte && win == 2'd2) |=> ((rsp_rdata & ~CM32) == 32'd0));

  // R6
  beyond_raz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (win == 2'd1 || win == 2'd2) && beyond) |=> (rsp_rdata == 32'd0));

  // R7
  type_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !req_byte && req_addr == ADDR_W'(4)) |=> (rsp_rdata == TYPE_EXP));

  // R4
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && req_byte) |=> (rsp_rdata[31:8] == 24'd0));

endmodule

bind irqcfg_bank irqcfg_bank_chk #(
  .ADDR_W    (ADDR_W),
  .NUM_IRQ   (NUM_IRQ),
  .NUM_CPU   (NUM_CPU),
  .PRIO_BITS (PRIO_BITS)
) i_irqcfg_bank_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_byte  (req_byte),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata)
);

// File: tb/test_irqcfg_bank.sv
module test_irqcfg_bank;

  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned NUM_IRQ   = 64;
  localparam int unsigned NUM_CPU   = 4;
  localparam int unsigned PRIO_BITS = 5;
  localparam logic [31:0] ID_VALUE  = 32'h0000_143B;
  localparam logic [7:0]  PMASK = 8'hF8;
  localparam logic [7:0]  CMASK = 8'h0F;
  localparam logic [31:0] TYPE_EXP = 32'h0000_0061;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic              req_byte = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irqcfg_bank #(
    .ADDR_W    (ADDR_W),
    .NUM_IRQ   (NUM_IRQ),
    .NUM_CPU   (NUM_CPU),
    .PRIO_BITS (PRIO_BITS),
    .ID_VALUE  (ID_VALUE)
  ) i_irqcfg_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_byte  (req_byte),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // reference model built from the requirements
  logic [7:0] pm [NUM_IRQ];
  logic [7:0] tm [NUM_IRQ];

  logic [31:0] q_exp [$];
  string       q_tag [$];

  function automatic logic [31:0] model_word(input logic [ADDR_W-1:0] a);
    logic [31:0] w = '0;
    int off = int'(a[9:0]) & ~3;
    case (a[11:10])
      2'd0: if (a[9:2] == 8'd1) w = TYPE_EXP; else if (a[9:2] == 8'd2) w = ID_VALUE;
      2'd1: if (off < NUM_IRQ) w = {pm[off+3], pm[off+2], pm[off+1], pm[off]};
      2'd2: if (off < NUM_IRQ) w = {tm[off+3], tm[off+2], tm[off+1], tm[off]};
      default: w = '0;
    endcase
    return w;
  endfunction

  task automatic issue(input logic wr, input logic by, input logic [ADDR_W-1:0] a,
                       input logic [31:0] d);
    req_valid = 1'b1; req_write = wr; req_byte = by; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_byte = 1'b0;
  endtask

  task automatic wr_word(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    int off = int'(a[9:0]) & ~3;
    for (int l = 0; l < 4; l++) begin
      if (off + l < NUM_IRQ) begin
        if (a[11:10] == 2'd1) pm[off+l] = d[8*l +: 8] & PMASK;
        if (a[11:10] == 2'd2) tm[off+l] = d[8*l +: 8] & CMASK;
      end
    end
    issue(1'b1, 1'b0, a, d);
  endtask

  task automatic wr_byte(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    int off = int'(a[9:0]);
    if (off < NUM_IRQ) begin
      if (a[11:10] == 2'd1) pm[off] = d & PMASK;
      if (a[11:10] == 2'd2) tm[off] = d & CMASK;
    end
    issue(1'b1, 1'b1, a, {24'hABCDEF, d});
  endtask

  task automatic rd_word(input logic [ADDR_W-1:0] a, input string tag);
    q_exp.push_back(model_word(a));
    q_tag.push_back(tag);
    issue(1'b0, 1'b0, a, 32'h0);
  endtask

  task automatic rd_byte(input logic [ADDR_W-1:0] a, input string tag);
    logic [31:0] w = model_word(a);
    q_exp.push_back({24'b0, w[8*a[1:0] +: 8]});
    q_tag.push_back(tag);
    issue(1'b0, 1'b1, a, 32'h0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_tests++;
      if (q_exp.size() == 0) begin
        n_fail++;
        $display("FAIL R9 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if (rsp_rdata !== e) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", t, rsp_rdata, e);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM_IRQ; i++) begin pm[i] = '0; tm[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_word(12'h400, "R1 prio word0");
    rd_word(12'h43C, "R1 prio last word");
    rd_word(12'h800, "R1 tgt word0");
    rd_word(12'h83C, "R1 tgt last word");

    // R7 / R10 control window
    rd_word(12'h004, "R7 type word");
    rd_word(12'h008, "R8 id word");
    rd_word(12'h00C, "R10 ctrl unused");
    rd_word(12'hC00, "R10 top window");

    // R3 all ones, R2 mixed pattern
    wr_word(12'h400, 32'hFFFF_FFFF);
    rd_word(12'h400, "R3 all-ones mask");
    wr_word(12'h404, 32'hFF7F_BF3F);
    rd_word(12'h404, "R2 pattern masked");
    wr_word(12'h400, 32'h0);
    rd_word(12'h400, "R2 cleared");

    // R4 byte lanes on priority
    wr_byte(12'h406, 8'h1F);
    rd_word(12'h404, "R4 prio byte write lane2");
    rd_byte(12'h405, "R4 prio byte read lane1");
    rd_byte(12'h407, "R4 prio byte read lane3");

    // R5 target masking, R4 on target
    wr_word(12'h800, 32'hFFFF_FFFF);
    rd_word(12'h800, "R5 tgt all ones");
    wr_word(12'h804, 32'h0103_020F);
    rd_word(12'h804, "R5 tgt pattern");
    wr_byte(12'h804, 8'hF6);
    rd_word(12'h804, "R4 tgt byte write lane0");
    rd_byte(12'h806, "R4 tgt byte read lane2");

    // R6 range limit
    wr_word(12'h43C, 32'h1234_5678);
    rd_word(12'h43C, "R6 last prio word kept");
    wr_word(12'h440, 32'hFFFF_FFFF);
    rd_word(12'h440, "R6 prio beyond limit");
    wr_byte(12'h441, 8'hFF);
    rd_byte(12'h441, "R6 prio byte beyond limit");
    wr_word(12'h840, 32'hFFFF_FFFF);
    rd_word(12'h840, "R6 tgt beyond limit");
    rd_word(12'h43C, "R6 last word unaffected");
    rd_word(12'h400, "R6 word0 unaffected");

    // R8 read-only words
    wr_word(12'h004, 32'hFFFF_FFFF);
    rd_word(12'h004, "R8 type after write");
    wr_word(12'h008, 32'h0);
    rd_word(12'h008, "R8 id after write");
    wr_byte(12'h004, 8'h00);
    rd_word(12'h004, "R8 type after byte write");

    // sweep of varied words, then read back everything (R2, R5)
    for (int k = 0; k < NUM_IRQ / 4; k++) begin
      wr_word(ADDR_W'(12'h400 + 4 * k), 32'h9E37_79B9 * (k + 1));
      wr_word(ADDR_W'(12'h800 + 4 * k), 32'h7F4A_7C15 ^ (32'h0101_0101 * k));
    end
    for (int k = 0; k < NUM_IRQ / 4; k++) begin
      rd_word(ADDR_W'(12'h400 + 4 * k), "R2 sweep prio");
      rd_word(ADDR_W'(12'h800 + 4 * k), "R5 sweep tgt");
    end

    // R9 no response left over after a write
    wr_word(12'h400, 32'h0);
    repeat (3) @(negedge clk);
    n_tests++;
    if (q_exp.size() != 0) begin
      n_fail++;
      $display("FAIL R9 pending responses actual=%0d expected=0", q_exp.size());
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule